// File: doc/BRIEF.md
# Unified Translation Buffer Lookup

This block is the associative stage of a data-side address translator. It keeps 64 translation entries in flops. Each entry holds a virtual page number, a per-entry compare mask, a physical page number, an 8-bit address-space tag and five attribute flags. A lookup presents a virtual page number, the current address-space tag and two mode bits. All entries are compared in parallel. One clock later the block reports one of three outcomes: a single hit with the entry index, a miss, or a multiple hit. A single hit also carries the entry's physical page number and flags.

A slot counter for victim selection moves forward on every lookup request. It returns to zero at a boundary value supplied from outside, or after the last slot. Software or a refill engine loads entries through a one-entry-per-cycle write port. A lookup issued in the same cycle as a write sees the table as it was before that write.

Top module: `utlb_lookup`

## Requirements
- R1: After reset every entry is invalid, so a lookup with valid checking enabled reports a miss. The slot counter is 0 and `res_valid` is low.
- R2: An entry matches when it is valid and its stored page number equals `lk_vpn` on every bit where its mask is 1. Mask bits that are 0 are not compared. A single match gives `res_status` = 1 (hit), `res_idx` = the entry number (0 to 63), and that entry's physical page number and flags.
- R3: With `lk_chk_id` = 1, a matching entry also needs either its shared flag set or its stored tag equal to `cur_asid`. Otherwise it does not match.
- R4: With `lk_chk_id` = 0, the stored tag and the shared flag play no part. Only the valid bit and the masked page number decide a match.
- R5: When two or more entries match, `res_status` = 2 (multi-hit) and `res_idx`, `res_ppn` and `res_flags` are all 0. The block never picks one of the matches by priority.
- R6: When no entry matches, `res_status` = 0 (miss) and `res_idx`, `res_ppn` and `res_flags` are all 0.
- R7: The result for a request sampled at a clock edge appears after that edge, with `res_valid` high for that one cycle. In cycles without a request, `res_valid` is low and the result fields keep their previous values.
- R8: The slot counter `repl_cnt` increases by one on each clock edge where `lk_req` is high. It holds its value on every other edge.
- R9: On a request, when the incremented counter value equals `wrap_bound` or reaches 64, the counter becomes 0 instead. If `wrap_bound` is 0, the counter only wraps after 63.
- R10: With `lk_ign_valid` = 1, the valid bit is disregarded. Invalid entries then match on the page number and tag rules alone.
- R11: When `wr_en` is high, the entry at `wr_idx` is loaded at the clock edge with `wr_vpn`, `wr_mask`, `wr_ppn` and `wr_asid`. Its flags come from `wr_flags` with bit 4 = valid, bit 3 = shared, bit 2 = writable, bit 1 = user-accessible and bit 0 = dirty. A lookup in the same cycle uses the entry's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 6 | Entry number to write |
| wr_vpn | input | 22 | Virtual page number to store |
| wr_mask | input | 22 | Compare mask to store |
| wr_ppn | input | 19 | Physical page number to store |
| wr_asid | input | 8 | Address-space tag to store |
| wr_flags | input | 5 | Flags: valid, shared, writable, user, dirty (bit 4 down to 0) |
| cur_asid | input | 8 | Current address-space tag |
| wrap_bound | input | 6 | Counter wrap boundary |
| lk_req | input | 1 | Lookup request strobe |
| lk_vpn | input | 22 | Virtual page number to look up |
| lk_chk_id | input | 1 | 1: address-space tag must match unless the entry is shared |
| lk_ign_valid | input | 1 | 1: disregard valid bits (associative write search) |
| res_valid | output | 1 | Result present this cycle |
| res_status | output | 2 | 0 miss, 1 hit, 2 multi-hit |
| res_idx | output | 6 | Hit entry number |
| res_ppn | output | 19 | Hit entry physical page number |
| res_flags | output | 5 | Hit entry flags |
| repl_cnt | output | 6 | Victim slot counter |

## Verification
A stored field that was corrupted or never written shows up on the first lookup that touches that entry. It appears one cycle after the request as a wrong status, index, page number or flag value. A lost or extra increment of the slot counter is visible on `repl_cnt` at the same result cycle. It stays visible on every request after it, because the bench model never resynchronises. Random rewrites copy page numbers between entries and narrow the masks, which creates overlaps. A fault in the overlap counting therefore shows up as a hit where a multi-hit belongs, or the reverse, within a few hundred lookups.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

  typedef enum logic [1:0] {
    ST_MISS  = 2'd0,
    ST_HIT   = 2'd1,
    ST_MULTI = 2'd2
  } utlb_status_e;

  // Flag word layout, most significant first.
  typedef struct packed {
    logic valid;
    logic shared;
    logic writable;
    logic user;
    logic dirty;
  } utlb_flags_t;

  localparam int unsigned FLAG_W = $bits(utlb_flags_t);
  localparam int unsigned ATTR_W = FLAG_W - 1;

endpackage

// File: rtl/utlb_entry_store.sv
module utlb_entry_store
  import utlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned VPN_W   = 22,
  parameter int unsigned PPN_W   = 19,
  parameter int unsigned ASID_W  = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [VPN_W-1:0]   wr_mask,
  input  logic [PPN_W-1:0]   wr_ppn,
  input  logic [ASID_W-1:0]  wr_asid,
  input  utlb_flags_t        wr_flags,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [ASID_W-1:0]  cur_asid,
  input  logic               lk_chk_id,
  input  logic               lk_ign_valid,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [ENTRIES-1:0] match_vec,
  output logic [PPN_W-1:0]   rd_ppn,
  output utlb_flags_t        rd_flags
);

  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][ATTR_W-1:0] attr_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  mask_q;
  logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
  logic [ENTRIES-1:0]             load_en;

  logic [ATTR_W-1:0] wr_attr;
  assign wr_attr = {wr_flags.shared, wr_flags.writable, wr_flags.user, wr_flags.dirty};

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic vpn_eq;
    logic id_ok;
    logic live;

    assign load_en[g] = wr_en && (wr_idx == IDX_W'(g));

    // Valid bit is the only per-entry field that needs a reset value.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
      end else if (load_en[g]) begin
        valid_q[g] <= wr_flags.valid;
      end
    end

    always_ff @(posedge clk) begin
      if (load_en[g]) begin
        attr_q[g] <= wr_attr;
        vpn_q[g]  <= wr_vpn;
        mask_q[g] <= wr_mask;
        ppn_q[g]  <= wr_ppn;
        asid_q[g] <= wr_asid;
      end
    end

    always_comb begin
      vpn_eq       = ((vpn_q[g] ^ lk_vpn) & mask_q[g]) == '0;
      id_ok        = !lk_chk_id || attr_q[g][ATTR_W-1] || (asid_q[g] == cur_asid);
      live         = lk_ign_valid || valid_q[g];
      match_vec[g] = live && id_ok && vpn_eq;
    end
  end

  always_comb begin
    rd_ppn   = ppn_q[rd_idx];
    rd_flags = utlb_flags_t'({valid_q[rd_idx], attr_q[rd_idx]});
  end

endmodule

// File: rtl/utlb_resolve.sv
module utlb_resolve #(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] match_vec,
  output logic               any_hit,
  output logic               multi_hit,
  output logic [IDX_W-1:0]   hit_idx
);

  // Scan keeps the first match and flags any later one as an overlap.
  always_comb begin
    any_hit   = 1'b0;
    multi_hit = 1'b0;
    hit_idx   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) begin
        if (any_hit) begin
          multi_hit = 1'b1;
        end else begin
          any_hit = 1'b1;
          hit_idx = IDX_W'(i);
        end
      end
    end
  end

endmodule

// File: rtl/utlb_repl_ctr.sv
module utlb_repl_ctr #(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [IDX_W-1:0] bound,
  output logic [IDX_W-1:0] cnt
);

  logic [IDX_W-1:0] cnt_q;
  logic [IDX_W-1:0] cnt_d;
  logic [IDX_W:0]   inc;
  logic             wrap;

  always_comb begin
    inc   = {1'b0, cnt_q} + 1'b1;
    wrap  = (inc == {1'b0, bound}) || (inc == (IDX_W+1)'(ENTRIES));
    cnt_d = cnt_q;
    if (adv) begin
      cnt_d = wrap ? '0 : inc[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/utlb_lookup.sv
module utlb_lookup
  import utlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned VPN_W   = 22,
  parameter int unsigned PPN_W   = 19,
  parameter int unsigned ASID_W  = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [VPN_W-1:0]  wr_mask,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [FLAG_W-1:0] wr_flags,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic [IDX_W-1:0]  wrap_bound,
  input  logic              lk_req,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic              lk_chk_id,
  input  logic              lk_ign_valid,
  output logic              res_valid,
  output logic [1:0]        res_status,
  output logic [IDX_W-1:0]  res_idx,
  output logic [PPN_W-1:0]  res_ppn,
  output logic [FLAG_W-1:0] res_flags,
  output logic [IDX_W-1:0]  repl_cnt
);

  // Reset asserts at once and is released on a clock edge.
  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [ENTRIES-1:0] match_vec;
  logic               any_hit;
  logic               multi_hit;
  logic [IDX_W-1:0]   hit_idx;
  logic [PPN_W-1:0]   sel_ppn;
  utlb_flags_t        sel_flags;

  utlb_entry_store #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PPN_W   (PPN_W),
    .ASID_W  (ASID_W)
  ) u_store (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .wr_vpn       (wr_vpn),
    .wr_mask      (wr_mask),
    .wr_ppn       (wr_ppn),
    .wr_asid      (wr_asid),
    .wr_flags     (utlb_flags_t'(wr_flags)),
    .lk_vpn       (lk_vpn),
    .cur_asid     (cur_asid),
    .lk_chk_id    (lk_chk_id),
    .lk_ign_valid (lk_ign_valid),
    .rd_idx       (hit_idx),
    .match_vec    (match_vec),
    .rd_ppn       (sel_ppn),
    .rd_flags     (sel_flags)
  );

  utlb_resolve #(
    .ENTRIES (ENTRIES)
  ) u_resolve (
    .match_vec (match_vec),
    .any_hit   (any_hit),
    .multi_hit (multi_hit),
    .hit_idx   (hit_idx)
  );

  utlb_repl_ctr #(
    .ENTRIES (ENTRIES)
  ) u_ctr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .adv   (lk_req),
    .bound (wrap_bound),
    .cnt   (repl_cnt)
  );

  // Result stage: next-state logic and its register.
  logic              vld_q,  vld_d;
  utlb_status_e      st_q,   st_d;
  logic [IDX_W-1:0]  idx_q,  idx_d;
  logic [PPN_W-1:0]  ppn_q,  ppn_d;
  logic [FLAG_W-1:0] flg_q,  flg_d;

  always_comb begin
    vld_d = lk_req;
    st_d  = st_q;
    idx_d = idx_q;
    ppn_d = ppn_q;
    flg_d = flg_q;
    if (lk_req) begin
      if (multi_hit) begin
        st_d  = ST_MULTI;
        idx_d = '0;
        ppn_d = '0;
        flg_d = '0;
      end else if (any_hit) begin
        st_d  = ST_HIT;
        idx_d = hit_idx;
        ppn_d = sel_ppn;
        flg_d = sel_flags;
      end else begin
        st_d  = ST_MISS;
        idx_d = '0;
        ppn_d = '0;
        flg_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      st_q  <= ST_MISS;
      idx_q <= '0;
      ppn_q <= '0;
      flg_q <= '0;
    end else begin
      vld_q <= vld_d;
      st_q  <= st_d;
      idx_q <= idx_d;
      ppn_q <= ppn_d;
      flg_q <= flg_d;
    end
  end

  assign res_valid  = vld_q;
  assign res_status = st_q;
  assign res_idx    = idx_q;
  assign res_ppn    = ppn_q;
  assign res_flags  = flg_q;

endmodule

// File: rtl/utlb_lookup_chk.sv
module utlb_lookup_chk #(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned PPN_W  = 19,
  parameter int unsigned FLAG_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_req,
  input logic [IDX_W-1:0]  wrap_bound,
  input logic              res_valid,
  input logic [1:0]        res_status,
  input logic [IDX_W-1:0]  res_idx,
  input logic [PPN_W-1:0]  res_ppn,
  input logic [FLAG_W-1:0] res_flags,
  input logic [IDX_W-1:0]  repl_cnt
);

  AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> res_valid); // R7
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !res_valid); // R7
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> ($stable(res_status) && $stable(res_idx))); // R7
  AST_LEGAL_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_status != 2'd3)); // R2
  AST_NONHIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_status != 2'd1) |-> (res_idx == '0 && res_ppn == '0 && res_flags == '0)); // R6
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> $stable(repl_cnt)); // R8
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> (repl_cnt == $past(repl_cnt) + 1'b1 || repl_cnt == '0)); // R8
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && ({1'b0, repl_cnt} + 1'b1) == {1'b0, wrap_bound}) |=> (repl_cnt == '0)); // R9

endmodule

bind utlb_lookup utlb_lookup_chk #(
  .IDX_W  (IDX_W),
  .PPN_W  (PPN_W),
  .FLAG_W (utlb_pkg::FLAG_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .lk_req     (lk_req),
  .wrap_bound (wrap_bound),
  .res_valid  (res_valid),
  .res_status (res_status),
  .res_idx    (res_idx),
  .res_ppn    (res_ppn),
  .res_flags  (res_flags),
  .repl_cnt   (repl_cnt)
);

// File: tb/sim_utlb_lookup.sv
`timescale 1ns/1ps
module sim_utlb_lookup;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [5:0]  wr_idx;
  logic [21:0] wr_vpn, wr_mask;
  logic [18:0] wr_ppn;
  logic [7:0]  wr_asid;
  logic [4:0]  wr_flags;
  logic [7:0]  cur_asid;
  logic [5:0]  wrap_bound;
  logic        lk_req;
  logic [21:0] lk_vpn;
  logic        lk_chk_id, lk_ign_valid;
  logic        res_valid;
  logic [1:0]  res_status;
  logic [5:0]  res_idx;
  logic [18:0] res_ppn;
  logic [4:0]  res_flags;
  logic [5:0]  repl_cnt;

  always #2 clk = ~clk;

  utlb_lookup u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn),
    .wr_mask(wr_mask), .wr_ppn(wr_ppn), .wr_asid(wr_asid), .wr_flags(wr_flags),
    .cur_asid(cur_asid), .wrap_bound(wrap_bound), .lk_req(lk_req), .lk_vpn(lk_vpn),
    .lk_chk_id(lk_chk_id), .lk_ign_valid(lk_ign_valid), .res_valid(res_valid),
    .res_status(res_status), .res_idx(res_idx), .res_ppn(res_ppn),
    .res_flags(res_flags), .repl_cnt(repl_cnt)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [21:0] m_vpn  [64];
  logic [21:0] m_mask [64];
  logic [18:0] m_ppn  [64];
  logic [7:0]  m_asid [64];
  logic [4:0]  m_flg  [64];
  logic        m_wr   [64];
  int          m_cnt;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Returns {status[1:0], index[5:0]}.
  function automatic logic [7:0] model(input logic [21:0] v, input bit chk_id, input bit ign, input logic [7:0] cur);
    int   hits = 0;
    logic [5:0] first = '0;
    for (int i = 0; i < 64; i++) begin
      bit live = ign ? m_wr[i] : (m_wr[i] && m_flg[i][4]);
      bit idok = !chk_id || m_flg[i][3] || (m_asid[i] == cur);
      bit vok  = ((m_vpn[i] ^ v) & m_mask[i]) == 22'd0;
      if (live && idok && vok) begin
        if (hits == 0) first = 6'(i);
        hits++;
      end
    end
    if (hits == 0) return {2'd0, 6'd0};
    if (hits == 1) return {2'd1, first};
    return {2'd2, 6'd0};
  endfunction

  function automatic int next_cnt(input int c, input int b);
    int n = c + 1;
    if (n == b || n == 64) n = 0;
    return n;
  endfunction

  task automatic wr(input int k, input logic [21:0] v, input logic [21:0] m,
                    input logic [18:0] p, input logic [7:0] a, input logic [4:0] f);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'(k); wr_vpn = v; wr_mask = m; wr_ppn = p; wr_asid = a; wr_flags = f;
    m_vpn[k] = v; m_mask[k] = m; m_ppn[k] = p; m_asid[k] = a; m_flg[k] = f; m_wr[k] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [21:0] v, input bit c, input bit ign, input logic [7:0] cur, input string req);
    logic [7:0] e;
    @(negedge clk);
    lk_req = 1'b1; lk_vpn = v; lk_chk_id = c; lk_ign_valid = ign; cur_asid = cur;
    e = model(v, c, ign, cur);
    m_cnt = next_cnt(m_cnt, int'(wrap_bound));
    @(negedge clk);
    lk_req = 1'b0;
    chk(res_valid == 1'b1, {req, " R7 valid"}, 32'(res_valid), 32'd1);
    chk(res_status == e[7:6], {req, " status"}, 32'(res_status), 32'(e[7:6]));
    chk(res_idx == e[5:0], {req, " index"}, 32'(res_idx), 32'(e[5:0]));
    if (e[7:6] == 2'd1) begin
      chk(res_ppn == m_ppn[e[5:0]], {req, " R2 ppn"}, 32'(res_ppn), 32'(m_ppn[e[5:0]]));
      chk(res_flags == m_flg[e[5:0]], {req, " R11 flags"}, 32'(res_flags), 32'(m_flg[e[5:0]]));
    end else begin
      chk(res_ppn == 19'd0 && res_flags == 5'd0, {req, " R6 zero fields"}, 32'({res_ppn, res_flags}), 32'd0);
    end
    chk(int'(repl_cnt) == m_cnt, {req, " R8 counter"}, 32'(repl_cnt), 32'(m_cnt));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  localparam logic [21:0] FULL = 22'h3FFFFF;

  initial begin
    logic [1:0] st_keep;
    void'($urandom(32'h1234ABCD));
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_vpn = '0; wr_mask = '0; wr_ppn = '0;
    wr_asid = '0; wr_flags = '0; cur_asid = '0; wrap_bound = '0; lk_req = 1'b0;
    lk_vpn = '0; lk_chk_id = 1'b0; lk_ign_valid = 1'b0; m_cnt = 0;
    for (int i = 0; i < 64; i++) begin
      m_wr[i] = 1'b0; m_flg[i] = '0; m_vpn[i] = '0; m_mask[i] = '0; m_ppn[i] = '0; m_asid[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk(res_valid == 1'b0, "R1 res_valid after reset", 32'(res_valid), 32'd0);
    chk(repl_cnt == 6'd0, "R1 counter after reset", 32'(repl_cnt), 32'd0);
    look(22'h0C3A05, 1'b0, 1'b0, 8'd0, "R1 empty table");
    look(22'h000000, 1'b1, 1'b0, 8'd0, "R1 empty table id mode");

    // Fill every slot with distinct pages.
    for (int i = 0; i < 64; i++)
      wr(i, {16'h0C3A, 6'(i)}, FULL, 19'($urandom), 8'(i % 4),
         {1'b1, (i % 8 == 7), 3'($urandom)});

    // R2: plain hit, masked hit
    look({16'h0C3A, 6'd10}, 1'b1, 1'b0, 8'd2, "R2 single hit");
    wr(40, 22'h155500, 22'h3FFF00, 19'h12345, 8'd9, 5'b10101);
    look(22'h1555A7, 1'b0, 1'b0, 8'd0, "R2 masked bits ignored");
    look(22'h1556A7, 1'b0, 1'b0, 8'd0, "R2 unmasked bit differs");

    // R3 / R4: identifier rules
    wr(12, 22'h2AAAAA, FULL, 19'h00777, 8'd5, 5'b10000);
    look(22'h2AAAAA, 1'b1, 1'b0, 8'd6, "R3 tag mismatch misses");
    look(22'h2AAAAA, 1'b1, 1'b0, 8'd5, "R3 tag equal hits");
    look(22'h2AAAAA, 1'b0, 1'b0, 8'd6, "R4 tag ignored");
    wr(12, 22'h2AAAAA, FULL, 19'h00777, 8'd5, 5'b11000);
    look(22'h2AAAAA, 1'b1, 1'b0, 8'd99, "R3 shared entry hits");

    // R5: overlap
    wr(50, 22'h2AAAAA, FULL, 19'h00001, 8'd5, 5'b10000);
    look(22'h2AAAAA, 1'b0, 1'b0, 8'd0, "R5 multi hit");

    // R10: invalid entry found only when valid bits ignored
    wr(50, 22'h3F0F0F, FULL, 19'h0ABCD, 8'd1, 5'b00110);
    look(22'h3F0F0F, 1'b0, 1'b0, 8'd0, "R10 invalid entry misses");
    look(22'h3F0F0F, 1'b0, 1'b1, 8'd0, "R10 invalid entry found");

    // R11: write and lookup in the same cycle use the old contents.
    begin
      logic [7:0] e;
      @(negedge clk);
      lk_req = 1'b1; lk_vpn = 22'h2AAAAA; lk_chk_id = 1'b0; lk_ign_valid = 1'b0; cur_asid = 8'd0;
      e = model(22'h2AAAAA, 1'b0, 1'b0, 8'd0);
      m_cnt = next_cnt(m_cnt, int'(wrap_bound));
      wr_en = 1'b1; wr_idx = 6'd12; wr_vpn = 22'h000111; wr_mask = FULL; wr_ppn = 19'h1; wr_asid = 8'd0; wr_flags = 5'b10000;
      @(negedge clk);
      lk_req = 1'b0; wr_en = 1'b0;
      m_vpn[12] = 22'h000111; m_ppn[12] = 19'h1; m_asid[12] = 8'd0; m_flg[12] = 5'b10000;
      chk(res_status == e[7:6] && res_idx == e[5:0], "R11 same-cycle write not seen",
          32'({res_status, res_idx}), 32'(e));
      look(22'h2AAAAA, 1'b0, 1'b0, 8'd0, "R11 write visible afterwards");
    end

    // R7: idle cycle holds result, valid low
    st_keep = res_status;
    @(negedge clk);
    chk(res_valid == 1'b0, "R7 idle no result", 32'(res_valid), 32'd0);
    chk(res_status == st_keep, "R7 idle status held", 32'(res_status), 32'(st_keep));
    chk(int'(repl_cnt) == m_cnt, "R8 idle counter held", 32'(repl_cnt), 32'(m_cnt));

    // R9: boundary wrap
    wrap_bound = 6'd5;
    for (int i = 0; i < 70; i++) look({16'h0C3A, 6'(i % 64)}, 1'b0, 1'b0, 8'd0, "R9 bounded wrap");
    wrap_bound = 6'd0;
    for (int i = 0; i < 66; i++) look({16'h0C3A, 6'(i % 64)}, 1'b1, 1'b0, 8'(i % 4), "R9 full wrap");

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int r = int'($urandom % 10);
      if (r < 2) begin
        int k = int'($urandom % 64);
        int j = int'($urandom % 64);
        logic [21:0] mk = ($urandom % 3 == 0) ? (FULL << ($urandom % 4)) : FULL;
        wr(k, m_vpn[j], mk, 19'($urandom), 8'($urandom % 4),
           {($urandom % 4 != 0), 4'($urandom)});
      end else begin
        int j = int'($urandom % 64);
        logic [21:0] v = m_vpn[j] ^ (($urandom % 4 == 0) ? 22'($urandom % 8) : 22'd0);
        look(v, 1'($urandom % 2), ($urandom % 8 == 0), 8'($urandom % 4), "R2 R3 R4 R5 R10 random");
      end
    end

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule